// File: doc/BRIEF.md
# Configuration Readback Serializer

This block sends the contents of a frame-organized configuration store out on one serial line. It runs entirely on its readback clock. A rising edge on an asynchronous trigger starts a readback. The trigger passes through a two-flop synchronizer before its edge is detected. A read-in-progress flag then stays high for the whole stream. During the stream, each frame is fetched through a synchronous read port with one-cycle latency and shifted out one bit per clock.

The stream is framed as follows:
- A short run of high filler bits opens the stream.
- Each frame has a low start bit, then its data bits, then a field of high check positions.
- After the last frame comes one more low start bit, then an 11-bit CRC.

In capture mode, selected bit positions of every frame carry register states instead of configuration bits. These states are sampled at the trigger and sent inverted. The capture field sits in the same place in every frame.

The parameters are frame count, frame length, the first capture position and the capture width per frame. The capture field must lie inside the frame, at bit 2 or above.

Top module: `rdbk_serializer`

## Requirements
- R1: A low-to-high change on `trig_in` is seen through two synchronizer stages. `rip` goes high on the third rising clock edge after `trig_in` rises, and stays low after the first two.
- R2: After `rip` rises, each later rising edge presents one new bit on `sdo`. The first five bits are 1, and the sixth is the low start bit of frame 0.
- R3: Frames are sent in address order 0 to NUM_FRAMES-1. Each frame is a 0 start bit, then FRAME_BITS data bits with word bit 0 first, then four 1 check bits.
- R4: Data bits 0 and 1 of frame 0 are always sent as 1, whatever the memory holds.
- R5: The final frame ends with seven 1 bits in place of the four check bits.
- R6: After the final frame come one 0 start bit and the 11 CRC bits. `rip` falls on the rising edge after the last CRC bit, so it is high for exactly stream-length + 1 cycles.
- R7: The CRC uses the polynomial x^11+x^9+x^8+x^7+x^2+1 (mask 0x385), in shift-left form, from an all-zero seed. It covers every bit before the final start bit and is sent MSB first.
- R8: With `cap_mode` = 1 at the trigger, `cap_state` is sampled when the readback starts. Frame f, data bit CAP_LO+j carries the inverse of that sample's bit f*CAP_N+j. Later changes of `cap_state` have no effect on that readback.
- R9: With `cap_mode` = 0, the capture positions carry the memory word's bits at those positions.
- R10: Data bits are the memory contents at the time each frame is read. A rewrite between readbacks appears in the next stream.
- R11: A trigger edge during an active readback is ignored. No second window follows, even if the trigger stays high.
- R12: While `rst` is high and whenever `rip` is low, `sdo` is 1. During reset, `rip` and `mem_rd` are 0.
- R13: Each readback issues exactly NUM_FRAMES single-cycle reads, only while `rip` is high, with addresses 0,1,... in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readback clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous readback trigger, rising edge starts |
| cap_mode | input | 1 | Capture mode select, sampled at trigger |
| cap_state | input | NUM_FRAMES*CAP_N | Monitored register and input states |
| mem_rd | output | 1 | Frame read strobe |
| mem_addr | output | clog2(NUM_FRAMES) | Frame address |
| mem_rdata | input | FRAME_BITS | Frame word, valid one cycle after the strobe |
| rip | output | 1 | Readback in progress |
| sdo | output | 1 | Serial readback data |

## Verification
The hardest situation to reach from the ports is a fresh trigger edge that lands in the middle of an active stream.

The stimulus lowers the trigger about twenty bits into a capture-mode readback and raises it again a few cycles later. It then holds the trigger high past the end of the stream, and the line must stay idle with no second window. In the same run, `cap_state` is flipped right after `rip` rises. The capture positions must still match the inverted value from before the flip.

// File: rtl/rdbk_pkg.sv
package rdbk_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_FILL, PH_START, PH_DATA, PH_CHECK, PH_FSTART, PH_CRC, PH_DONE
  } rdbk_phase_e;

  localparam int FILL_N       = 5;
  localparam int LEAD_ONES    = 2;
  localparam int CHECK_N      = 4;
  localparam int LAST_CHECK_N = 7;
  localparam int CRC_W        = 11;
  localparam logic [CRC_W-1:0] CRC_POLY = 11'h385;
endpackage

// File: rtl/rdbk_trig_sync.sv
module rdbk_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic rise
);
  logic sync_q [STAGES];
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= trig_in;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else     sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rdbk_capture.sv
module rdbk_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         mode_in,
  input  logic [W-1:0] state_in,
  output logic         mode_q,
  output logic [W-1:0] inv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      inv_q  <= '0;
    end else if (load) begin
      mode_q <= mode_in;
      inv_q  <= mode_in ? ~state_in : '0;
    end
  end
endmodule

// File: rtl/rdbk_crc.sv
module rdbk_crc #(
  parameter int           W    = 11,
  parameter logic [W-1:0] POLY = 11'h385
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] crc_q
);
  logic [W-1:0] crc_next;

  always_comb begin
    crc_next = {crc_q[W-2:0], 1'b0} ^ ({W{crc_q[W-1] ^ din}} & POLY);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= '0;
    else if (shift)   crc_q <= crc_next;
  end
endmodule

// File: rtl/rdbk_serializer.sv
module rdbk_serializer
  import rdbk_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int FRAME_BITS = 16,
  parameter int CAP_LO     = 4,
  parameter int CAP_N      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int FA_W  = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int CAP_W = NUM_FRAMES * CAP_N
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trig_in,
  input  logic                  cap_mode,
  input  logic [CAP_W-1:0]      cap_state,
  output logic                  mem_rd,
  output logic [FA_W-1:0]       mem_addr,
  input  logic [FRAME_BITS-1:0] mem_rdata,
  output logic                  rip,
  output logic                  sdo
);
  localparam int IDX_W = $clog2(FRAME_BITS + LAST_CHECK_N + CRC_W);
  localparam int BI_W  = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int CI_W  = (CAP_W > 1) ? $clog2(CAP_W) : 1;

  localparam logic [IDX_W-1:0] FILL_LAST  = IDX_W'(FILL_N - 1);
  localparam logic [IDX_W-1:0] DATA_LAST  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] CHK_LAST   = IDX_W'(CHECK_N - 1);
  localparam logic [IDX_W-1:0] TAIL_LAST  = IDX_W'(LAST_CHECK_N - 1);
  localparam logic [IDX_W-1:0] CRC_LAST   = IDX_W'(CRC_W - 1);
  localparam logic [IDX_W-1:0] LEAD_END   = IDX_W'(LEAD_ONES);
  localparam logic [IDX_W-1:0] CAP_FIRST  = IDX_W'(CAP_LO);
  localparam logic [IDX_W-1:0] CAP_END    = IDX_W'(CAP_LO + CAP_N);
  localparam logic [FA_W-1:0]  FRAME_LAST = FA_W'(NUM_FRAMES - 1);

  rdbk_phase_e           phase_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FA_W-1:0]       frame_q;
  logic [FRAME_BITS-1:0] fbuf_q;
  logic                  sdo_q, rip_q, rd_q;
  logic [FA_W-1:0]       addr_q;

  logic                  trig_rise;
  logic                  start_go;
  logic                  cap_mode_q;
  logic [CAP_W-1:0]      cap_inv_q;
  logic [CRC_W-1:0]      crc_q;
  logic                  cur_bit;
  logic                  crc_shift;
  logic                  data_bit;
  logic [FRAME_BITS-1:0] word;
  logic [CI_W-1:0]       cap_sel;
  logic [3:0]            crc_sel;
  logic                  in_cap, in_lead, last_frame;

  rdbk_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .trig_in(trig_in), .rise(trig_rise)
  );

  assign start_go = trig_rise && (phase_q == PH_IDLE);

  rdbk_capture #(.W(CAP_W)) u_cap (
    .clk(clk), .rst(rst), .load(start_go), .mode_in(cap_mode),
    .state_in(cap_state), .mode_q(cap_mode_q), .inv_q(cap_inv_q)
  );

  rdbk_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .clear(start_go), .shift(crc_shift),
    .din(cur_bit), .crc_q(crc_q)
  );

  // Bit selection for the data field of the current frame
  always_comb begin
    word       = (idx_q == '0) ? mem_rdata : fbuf_q;
    last_frame = (frame_q == FRAME_LAST);
    in_lead    = (frame_q == '0) && (idx_q < LEAD_END);
    in_cap     = (idx_q >= CAP_FIRST) && (idx_q < CAP_END);
    cap_sel    = CI_W'(frame_q) * CI_W'(CAP_N) + CI_W'(idx_q - CAP_FIRST);
    crc_sel    = 4'(CRC_W - 1) - idx_q[3:0];
    if (in_lead)                  data_bit = 1'b1;
    else if (in_cap && cap_mode_q) data_bit = cap_inv_q[cap_sel];
    else                          data_bit = word[idx_q[BI_W-1:0]];
  end

  always_comb begin
    unique case (phase_q)
      PH_START, PH_FSTART: cur_bit = 1'b0;
      PH_DATA:             cur_bit = data_bit;
      PH_CRC:              cur_bit = crc_q[crc_sel];
      default:             cur_bit = 1'b1;
    endcase
    crc_shift = (phase_q == PH_FILL) || (phase_q == PH_START) ||
                (phase_q == PH_DATA) || (phase_q == PH_CHECK);
  end

  // Frame sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      frame_q <= '0;
      fbuf_q  <= '0;
      sdo_q   <= 1'b1;
      rip_q   <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      rd_q <= 1'b0;
      if (phase_q != PH_IDLE) sdo_q <= cur_bit;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_go) begin
            phase_q <= PH_FILL;
            idx_q   <= '0;
            frame_q <= '0;
            rip_q   <= 1'b1;
          end
        end
        PH_FILL: begin
          if (idx_q == FILL_LAST) begin
            phase_q <= PH_START;
            idx_q   <= '0;
            rd_q    <= 1'b1;
            addr_q  <= frame_q;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_START: begin
          phase_q <= PH_DATA;
          idx_q   <= '0;
        end
        PH_DATA: begin
          if (idx_q == '0) fbuf_q <= mem_rdata;
          if (idx_q == DATA_LAST) begin
            phase_q <= PH_CHECK;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_CHECK: begin
          if (idx_q == (last_frame ? TAIL_LAST : CHK_LAST)) begin
            idx_q <= '0;
            if (last_frame) begin
              phase_q <= PH_FSTART;
            end else begin
              phase_q <= PH_START;
              frame_q <= frame_q + 1'b1;
              rd_q    <= 1'b1;
              addr_q  <= frame_q + 1'b1;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_FSTART: begin
          phase_q <= PH_CRC;
          idx_q   <= '0;
        end
        PH_CRC: begin
          if (idx_q == CRC_LAST) phase_q <= PH_DONE;
          else                   idx_q   <= idx_q + 1'b1;
        end
        PH_DONE: begin
          phase_q <= PH_IDLE;
          rip_q   <= 1'b0;
          sdo_q   <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign sdo      = sdo_q;
  assign rip      = rip_q;
  assign mem_rd   = rd_q;
  assign mem_addr = addr_q;
endmodule

// File: rtl/rdbk_serializer_chk.sv
module rdbk_serializer_chk
  import rdbk_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int FRAME_BITS = 16,
  parameter int FA_W       = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            rip,
  input logic            sdo,
  input logic            mem_rd,
  input logic [FA_W-1:0] mem_addr,
  input logic            trig_rise
);
  localparam int STREAM_LEN = FILL_N + NUM_FRAMES * (1 + FRAME_BITS + CHECK_N)
                              + (LAST_CHECK_N - CHECK_N) + 1 + CRC_W;
  localparam logic [15:0] WIN = 16'(STREAM_LEN + 1);

  logic [15:0] win_cnt;
  always_ff @(posedge clk) begin
    if (rst)      win_cnt <= '0;
    else if (rip) win_cnt <= win_cnt + 1'b1;
    else          win_cnt <= '0;
  end

  AST_RIP_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(rip) |-> $past(trig_rise)); // R1
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(rip) |-> (win_cnt == WIN)); // R6
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !rip |-> sdo); // R12
  AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> rip); // R13
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd); // R13
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (int'(mem_addr) < NUM_FRAMES)); // R13
endmodule

bind rdbk_serializer rdbk_serializer_chk #(
  .NUM_FRAMES(NUM_FRAMES), .FRAME_BITS(FRAME_BITS), .FA_W(FA_W)
) u_chk (
  .clk(clk), .rst(rst), .rip(rip), .sdo(sdo), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .trig_rise(trig_rise)
);

// File: tb/tb_rdbk_serializer.sv
module tb_rdbk_serializer;
  localparam int NF  = 4;
  localparam int FB  = 16;
  localparam int CL  = 4;
  localparam int CN  = 4;
  localparam int CW  = NF * CN;
  localparam int FAW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, trig_in, cap_mode;
  logic [CW-1:0] cap_state;
  logic          mem_rd;
  logic [FAW-1:0] mem_addr;
  logic [FB-1:0] mem_rdata;
  logic          rip, sdo;

  rdbk_serializer #(.NUM_FRAMES(NF), .FRAME_BITS(FB), .CAP_LO(CL), .CAP_N(CN)) dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .cap_mode(cap_mode),
    .cap_state(cap_state), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .rip(rip), .sdo(sdo)
  );

  // Frame memory model: synchronous read, one-cycle latency
  logic [FB-1:0] mem [NF];
  initial mem_rdata = '0;
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Scoreboard
  bit    exp_q [$];
  string tag_q [$];
  logic [10:0] sb_crc;
  int    rd_seen;
  bit    rip_prev = 0;
  bit    mon_b;
  string mon_t;

  task automatic push_bit(input bit b, input string tag, input bit fold);
    exp_q.push_back(b);
    tag_q.push_back(tag);
    if (fold) sb_crc = {sb_crc[9:0], 1'b0} ^ ({11{sb_crc[10] ^ b}} & 11'h385);
  endtask

  task automatic build_expect(input bit mode, input logic [CW-1:0] cs);
    sb_crc = '0;
    for (int i = 0; i < 5; i++) push_bit(1'b1, "R2", 1'b1);
    for (int f = 0; f < NF; f++) begin
      push_bit(1'b0, (f == 0) ? "R2" : "R3", 1'b1);
      for (int b = 0; b < FB; b++) begin
        if (f == 0 && b < 2)                 push_bit(1'b1, "R4", 1'b1);
        else if (b >= CL && b < CL + CN && mode) push_bit(~cs[f*CN + b - CL], "R8", 1'b1);
        else if (b >= CL && b < CL + CN)     push_bit(mem[f][b], "R9", 1'b1);
        else                                 push_bit(mem[f][b], "R10", 1'b1);
      end
      if (f == NF - 1) for (int i = 0; i < 7; i++) push_bit(1'b1, "R5", 1'b1);
      else             for (int i = 0; i < 4; i++) push_bit(1'b1, "R3", 1'b1);
    end
    push_bit(1'b0, "R6", 1'b0);
    for (int i = 10; i >= 0; i--) push_bit(sb_crc[i], "R7", 1'b0);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rip && rip_prev) begin
        if (exp_q.size() == 0) chk(1'b0, "R6", "bit beyond stream end", 1, 0);
        else begin
          mon_b = exp_q.pop_front();
          mon_t = tag_q.pop_front();
          chk(sdo === mon_b, mon_t, "stream bit", int'(sdo), int'(mon_b));
        end
      end
      if (mem_rd) begin
        chk(int'(mem_addr) == rd_seen, "R13", "read address", int'(mem_addr), rd_seen);
        rd_seen++;
      end
      rip_prev = rip;
    end
  end

  task automatic run_readback(input bit mode, input logic [CW-1:0] cs, input bit retrig);
    cap_mode  = mode;
    cap_state = cs;
    build_expect(mode, cs);
    rd_seen = 0;
    @(negedge clk) trig_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(rip == 1'b0, "R1", "rip before sync delay", int'(rip), 0);
    @(negedge clk);
    chk(rip == 1'b1, "R1", "rip on third edge", int'(rip), 1);
    cap_state = ~cs; // R8: later change must not matter
    if (retrig) begin
      repeat (20) @(negedge clk);
      trig_in = 1'b0;
      repeat (4) @(negedge clk);
      trig_in = 1'b1; // R11: edge while busy
    end
    for (int i = 0; i < 400 && rip; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "bits left unsent", exp_q.size(), 0);
    chk(rd_seen == NF, "R13", "frame reads per readback", rd_seen, NF);
    repeat (12) begin
      @(negedge clk);
      chk(rip == 1'b0, "R11", "no second window", int'(rip), 0);
      chk(sdo == 1'b1, "R12", "idle line high", int'(sdo), 1);
    end
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; trig_in = 1'b0; cap_mode = 1'b0; cap_state = '0;
    for (int f = 0; f < NF; f++) mem[f] = FB'((f + 1) * 16'h3B5D ^ 16'hA61C);
    repeat (3) @(negedge clk);
    chk(rip == 1'b0, "R12", "reset rip", int'(rip), 0);
    chk(sdo == 1'b1, "R12", "reset sdo", int'(sdo), 1);
    chk(mem_rd == 1'b0, "R12", "reset mem_rd", int'(mem_rd), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    run_readback(1'b0, 16'hF0F0, 1'b0);               // plain, R9 capture off
    run_readback(1'b1, 16'h3C5A, 1'b0);               // R8 capture on
    for (int f = 0; f < NF; f++) mem[f] = FB'(16'h5A0F ^ (f * 16'h1111)); // R10 rewrite
    run_readback(1'b1, 16'h0FF1, 1'b1);               // R11 retrigger while busy
    for (int f = 0; f < NF; f++) mem[f] = '0;
    run_readback(1'b0, 16'hFFFF, 1'b0);               // R4 forced ones on empty memory

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule